// File: doc/BRIEF.md
# Halfword Pack Execution Unit

This unit executes the two halfword-pack operations of a 32-bit processor pipeline. Each operation builds a result word from one halfword of the first operand, taken unchanged, and one halfword of a shifted copy of the second operand. The keep-low form keeps the first operand's low halfword and fills the high halfword from the second operand after a logical left shift. The keep-high form keeps the first operand's high halfword and fills the low halfword from the second operand after an arithmetic right shift.

The pipeline delivers an issue strobe together with the operands, a 5-bit shift field, a 4-bit destination index, a 4-bit condition code and the current N, Z, C, V flags. One clock later the unit presents the merged result, the destination index, a result-valid strobe and a write-enable for the register file. The write-enable is gated by the condition code and by a destination check. A destination of the stack pointer (index 13) or the program counter (index 15) is refused and flagged as illegal. The flags are never modified. They are captured with each issue and handed on unchanged.

The unit has no state machine. It is a single registered stage with a reset.

Top module: `hpack_unit`

## Requirements
- R1: `res_vld_o` is high in exactly the cycle after a cycle with `iss_vld` high, and low otherwise; `res_o`, `dst_o` and `wr_en_o` for that issue appear in the same cycle.
- R2: With `op_sel` = 0 (keep-low), `res_o[15:0]` equals `opa[15:0]` and `res_o[31:16]` equals bits [31:16] of `opb` shifted left logically by `shamt` (0 to 31, where 0 means unshifted).
- R3: With `op_sel` = 1 (keep-high), `res_o[31:16]` equals `opa[31:16]` and `res_o[15:0]` equals bits [15:0] of `opb` shifted right arithmetically by `shamt` for values 1 to 31.
- R4: With `op_sel` = 1 and `shamt` = 0, the shift is 32, so every bit of `res_o[15:0]` equals `opb[31]`.
- R5: Condition codes are evaluated over `nzcv_i` (N bit 3, Z bit 2, C bit 1, V bit 0): 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V). When the condition fails, `wr_en_o` stays low while `res_vld_o` is still raised.
- R6: Codes 1110 and 1111 always pass.
- R7: An issue with `dst_idx` equal to 13 or 15 raises `illegal_o` for exactly the one result cycle and holds `wr_en_o` low, whatever the condition outcome.
- R8: `nzcv_o` takes the value of `nzcv_i` from each issue cycle, unchanged.
- R9: A synchronous active-high `rst` clears `res_vld_o`, `wr_en_o`, `illegal_o`, `res_o`, `dst_o` and `nzcv_o` to zero.
- R10: In a cycle after no issue, `wr_en_o` and `illegal_o` are low and `res_o`, `dst_o` and `nzcv_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Issue strobe for the operation on the inputs |
| op_sel | input | 1 | 0 = keep-low with left shift, 1 = keep-high with arithmetic right shift |
| opa | input | 32 | First operand, source of the kept halfword |
| opb | input | 32 | Second operand, source of the shifted halfword |
| shamt | input | 5 | Shift field |
| dst_idx | input | 4 | Destination register index |
| cond | input | 4 | Condition code |
| nzcv_i | input | 4 | Current flags N, Z, C, V (bits 3..0) |
| res_o | output | 32 | Merged result |
| wr_en_o | output | 1 | Register-file write enable |
| dst_o | output | 4 | Destination index of the result |
| res_vld_o | output | 1 | Result valid |
| illegal_o | output | 1 | Destination was SP or PC |
| nzcv_o | output | 4 | Flags passed on unchanged |

## Verification
The hardest corner to reach is the combination of a failing condition with a forbidden destination, because `wr_en_o` is low for both reasons and only `illegal_o` separates them. Random stimulus rarely lines up the matching flags and index. The bench therefore sweeps all 16 condition codes against all 16 flag patterns. It repeats the sweep with destinations of 13 and 15. It then adds directed shift amounts of 0, 1, 15, 16 and 31 on operands with the sign bit both set and clear, so that the shift of 32 is hit in both polarities.

// File: rtl/hpack_pkg.sv
package hpack_pkg;

    typedef enum logic {
        OP_KEEP_LO = 1'b0,
        OP_KEEP_HI = 1'b1
    } pack_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'b0000,
        CC_NE = 4'b0001,
        CC_CS = 4'b0010,
        CC_CC = 4'b0011,
        CC_MI = 4'b0100,
        CC_PL = 4'b0101,
        CC_VS = 4'b0110,
        CC_VC = 4'b0111,
        CC_HI = 4'b1000,
        CC_LS = 4'b1001,
        CC_GE = 4'b1010,
        CC_LT = 4'b1011,
        CC_GT = 4'b1100,
        CC_LE = 4'b1101,
        CC_AL = 4'b1110,
        CC_UN = 4'b1111
    } cond_e;

endpackage

// File: rtl/hpack_cond_eval.sv
module hpack_cond_eval
    import hpack_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] nzcv,
    output logic       pass
);

    logic fn, fz, fc, fv;

    assign fn = nzcv[3];
    assign fz = nzcv[2];
    assign fc = nzcv[1];
    assign fv = nzcv[0];

    always_comb begin
        unique case (cond_e'(cond))
            CC_EQ:   pass = fz;
            CC_NE:   pass = !fz;
            CC_CS:   pass = fc;
            CC_CC:   pass = !fc;
            CC_MI:   pass = fn;
            CC_PL:   pass = !fn;
            CC_VS:   pass = fv;
            CC_VC:   pass = !fv;
            CC_HI:   pass = fc && !fz;
            CC_LS:   pass = !fc || fz;
            CC_GE:   pass = (fn == fv);
            CC_LT:   pass = (fn != fv);
            CC_GT:   pass = !fz && (fn == fv);
            CC_LE:   pass = fz || (fn != fv);
            CC_AL:   pass = 1'b1;
            CC_UN:   pass = 1'b1;
            default: pass = 1'b1;
        endcase
    end

endmodule

// File: rtl/hpack_merge.sv
module hpack_merge
    import hpack_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF  = DATA_W / 2,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              op_sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] res
);

    logic [SH_W:0]       ramt;
    logic [DATA_W-1:0]   sll;
    logic [DATA_W-1:0]   sra;
    logic [DATA_W-1:0]   shifted;

    // A zero field on the right-shift form encodes a full-width shift.
    assign ramt = (shamt == '0) ? (SH_W+1)'(DATA_W) : {1'b0, shamt};
    assign sll  = b << shamt;
    assign sra  = DATA_W'($signed(b) >>> ramt);

    always_comb begin
        unique case (pack_op_e'(op_sel))
            OP_KEEP_LO: begin
                shifted = sll;
                res     = {shifted[DATA_W-1:HALF], a[HALF-1:0]};
            end
            OP_KEEP_HI: begin
                shifted = sra;
                res     = {a[DATA_W-1:HALF], shifted[HALF-1:0]};
            end
            default: begin
                shifted = sll;
                res     = {shifted[DATA_W-1:HALF], a[HALF-1:0]};
            end
        endcase
    end

endmodule

// File: rtl/hpack_unit.sv
module hpack_unit
    import hpack_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 4,
    parameter int SP_IDX    = 13,
    parameter int PC_IDX    = 15,
    localparam int SH_W     = $clog2(DATA_W),
    localparam int HALF     = DATA_W / 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_vld,
    input  logic                 op_sel,
    input  logic [DATA_W-1:0]    opa,
    input  logic [DATA_W-1:0]    opb,
    input  logic [SH_W-1:0]      shamt,
    input  logic [REG_IDX_W-1:0] dst_idx,
    input  logic [3:0]           cond,
    input  logic [3:0]           nzcv_i,
    output logic [DATA_W-1:0]    res_o,
    output logic                 wr_en_o,
    output logic [REG_IDX_W-1:0] dst_o,
    output logic                 res_vld_o,
    output logic                 illegal_o,
    output logic [3:0]           nzcv_o
);

    localparam logic [REG_IDX_W-1:0] SP_CODE = REG_IDX_W'(SP_IDX);
    localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);

    logic              cond_pass;
    logic              dst_bad;
    logic [DATA_W-1:0] merged;

    hpack_cond_eval u_cond (
        .cond (cond),
        .nzcv (nzcv_i),
        .pass (cond_pass)
    );

    hpack_merge #(.DATA_W(DATA_W)) u_merge (
        .op_sel (op_sel),
        .a      (opa),
        .b      (opb),
        .shamt  (shamt),
        .res    (merged)
    );

    assign dst_bad = (dst_idx == SP_CODE) || (dst_idx == PC_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld_o <= 1'b0;
            wr_en_o   <= 1'b0;
            illegal_o <= 1'b0;
            res_o     <= '0;
            dst_o     <= '0;
            nzcv_o    <= '0;
        end else begin
            res_vld_o <= iss_vld;
            wr_en_o   <= iss_vld && cond_pass && !dst_bad;
            illegal_o <= iss_vld && dst_bad;
            if (iss_vld) begin
                res_o  <= merged;
                dst_o  <= dst_idx;
                nzcv_o <= nzcv_i;
            end
        end
    end

    AST_VLD_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        iss_vld |=> res_vld_o); // R1
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (rst)
        !iss_vld |=> !res_vld_o); // R1
    AST_LO_HALF_KEPT: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && !op_sel) |=> (res_o[HALF-1:0] == $past(opa[HALF-1:0]))); // R2
    AST_HI_HALF_KEPT: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && op_sel) |=> (res_o[DATA_W-1:HALF] == $past(opa[DATA_W-1:HALF]))); // R3
    AST_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && (cond == CC_AL) && (dst_idx != SP_CODE) && (dst_idx != PC_CODE)) |=> wr_en_o); // R6
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!wr_en_o && res_vld_o && ((dst_o == SP_CODE) || (dst_o == PC_CODE)))); // R7
    AST_FLAGS_CARRIED: assert property (@(posedge clk) disable iff (rst)
        iss_vld |=> (nzcv_o == $past(nzcv_i))); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !iss_vld |=> (!wr_en_o && !illegal_o && $stable(res_o) && $stable(dst_o))); // R10

endmodule

// File: tb/hpack_unit_tb.sv
`timescale 1ns/1ps
module hpack_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_vld = 1'b0;
    logic        op_sel = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  shamt = '0;
    logic [3:0]  dst_idx = '0;
    logic [3:0]  cond = '0;
    logic [3:0]  nzcv_i = '0;
    logic [31:0] res_o;
    logic        wr_en_o;
    logic [3:0]  dst_o;
    logic        res_vld_o;
    logic        illegal_o;
    logic [3:0]  nzcv_o;

    int checks = 0;
    int failures = 0;

    logic [31:0] e_res = '0;
    logic        e_we = 1'b0;
    logic [3:0]  e_dst = '0;
    logic        e_vld = 1'b0;
    logic        e_ill = 1'b0;
    logic [3:0]  e_f = '0;
    string       res_tag = "R9";
    string       we_tag = "R9";

    always #4 clk = ~clk;

    hpack_unit u_dut (
        .clk(clk), .rst(rst), .iss_vld(iss_vld), .op_sel(op_sel),
        .opa(opa), .opb(opb), .shamt(shamt), .dst_idx(dst_idx),
        .cond(cond), .nzcv_i(nzcv_i), .res_o(res_o), .wr_en_o(wr_en_o),
        .dst_o(dst_o), .res_vld_o(res_vld_o), .illegal_o(illegal_o),
        .nzcv_o(nzcv_o)
    );

    function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3];
        bit z = f[2];
        bit cy = f[1];
        bit v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] ref_pack(input logic op, input logic [31:0] a,
                                             input logic [31:0] b, input logic [4:0] s);
        logic [31:0] lo_out;
        logic [15:0] rs;
        int n;
        if (!op) begin
            lo_out = b;
            for (int k = 0; k < s; k++) lo_out = {lo_out[30:0], 1'b0};
            return {lo_out[31:16], a[15:0]};
        end
        n = (s == 0) ? 32 : int'(s);
        for (int k = 0; k < 16; k++)
            rs[k] = (k + n > 31) ? b[31] : b[k + n];
        return {a[31:16], rs};
    endfunction

    task automatic chk1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chkw(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk1("R1", "res_vld_o", res_vld_o, e_vld);
        chkw(res_tag, "res_o", res_o, e_res);
        chkw(e_vld ? "R1" : "R10", "dst_o", {28'd0, dst_o}, {28'd0, e_dst});
        chk1(we_tag, "wr_en_o", wr_en_o, e_we);
        chk1(e_vld ? "R7" : "R10", "illegal_o", illegal_o, e_ill);
        chkw(e_vld ? "R8" : "R10", "nzcv_o", {28'd0, nzcv_o}, {28'd0, e_f});
    endtask

    // At a falling edge: check what the last rising edge produced, then drive the next cycle.
    task automatic step(input bit v, input bit op, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] s, input logic [3:0] d, input logic [3:0] c,
                        input logic [3:0] f);
        bit bad;
        @(negedge clk);
        compare_all();
        iss_vld = v; op_sel = op; opa = a; opb = b; shamt = s;
        dst_idx = d; cond = c; nzcv_i = f;
        e_vld = v;
        if (v) begin
            bad = (d == 4'd13) || (d == 4'd15);
            e_res = ref_pack(op, a, b, s);
            e_dst = d;
            e_f = f;
            e_ill = bad;
            e_we = ref_cond(c, f) && !bad;
            res_tag = !op ? "R2" : ((s == 0) ? "R4" : "R3");
            we_tag = bad ? "R7" : ((c >= 4'd14) ? "R6" : "R5");
        end else begin
            e_ill = 1'b0;
            e_we = 1'b0;
            res_tag = "R10";
            we_tag = "R10";
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [4:0] sh_list [5];
        sh_list = '{5'd0, 5'd1, 5'd15, 5'd16, 5'd31};
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all();
        rst = 1'b0;
        // directed: unshifted keep-low, right shift by 1, full-width shift both signs
        step(1, 0, 32'h1111_2222, 32'hABCD_5678, 5'd0, 4'd3, 4'd14, 4'h0); // R2
        step(1, 1, 32'hCAFE_0000, 32'h8000_0001, 5'd1, 4'd4, 4'd14, 4'h0); // R3
        step(1, 1, 32'h1234_5678, 32'h8000_0000, 5'd0, 4'd5, 4'd14, 4'h0); // R4
        step(1, 1, 32'h1234_5678, 32'h7FFF_FFFF, 5'd0, 4'd6, 4'd15, 4'h0); // R4 R6
        step(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 4'd7, 4'd0, 4'hF); // R10
        step(0, 1, 32'h0, 32'h0, 5'd0, 4'd13, 4'd14, 4'h5); // R10
        // shift sweep in both forms and sign polarities
        for (int i = 0; i < 5; i++)
            for (int op = 0; op < 2; op++) begin
                step(1, op[0], 32'h5A5A_A5A5, 32'h8123_4567, sh_list[i], 4'd2, 4'd14, 4'h3);
                step(1, op[0], 32'hA5A5_5A5A, 32'h7123_4567, sh_list[i], 4'd1, 4'd14, 4'hC);
            end
        // R5 R6 R7: all codes against all flags, legal and forbidden destinations
        for (int d = 0; d < 3; d++)
            for (int c = 0; c < 16; c++)
                for (int f = 0; f < 16; f++)
                    step(1, f[0], $urandom, $urandom, 5'(c + f), (d == 0) ? 4'd9 : ((d == 1) ? 4'd13 : 4'd15),
                         4'(c), 4'(f));
        // random mix with idle gaps
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, $urandom, $urandom, $urandom, 5'($urandom),
                 4'($urandom), 4'($urandom), 4'($urandom));
        step(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        // R9: reset in mid-run clears outputs
        rst = 1'b1;
        e_vld = 0; e_we = 0; e_ill = 0; e_res = '0; e_dst = '0; e_f = '0;
        res_tag = "R9"; we_tag = "R9";
        @(negedge clk);
        compare_all();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule